// File: doc/BRIEF.md
# RRIP Set Replacement Unit

This unit keeps the replacement state of one cache set. Each way stores a 2-bit re-reference prediction value (RRPV) that estimates how soon the line will be used again: 0 immediate, 1 intermediate, 2 far, 3 distant. A hit on a way marks it immediate. A fill writes an insertion value that the cache controller supplies. Writing 2 gives scan-resistant insertion and writing 3 gives thrash-resistant insertion. Only a way predicted distant may be evicted.

The controller raises `vic_req` and holds it until `vic_vld` goes high. A small state machine handles the request. `ST_IDLE` waits for a request. If a distant way exists, `ST_IDLE` moves to `ST_FOUND`; if none does, it moves to `ST_AGE`. In `ST_AGE` every way's value rises by one each cycle until some way reaches 3, and the state then moves to `ST_FOUND`. In `ST_FOUND` the unit reports the lowest-numbered distant way. If a hit takes away the last distant way while the request is still held, `ST_FOUND` returns to `ST_AGE`. Dropping the request in `ST_AGE` or `ST_FOUND` returns the machine to `ST_IDLE`.

Top module: `rrip_set_repl`

## Requirements
- R1: After reset every way holds 3 and `vic_vld` is low. A request sampled in the first cycle gives `vic_vld`=1 and `vic_way`=0 after one clock edge.
- R2: A hit on a way sets that way's value to 0, so the way is no longer a victim candidate.
- R3: `vic_vld` is high only while the reported way holds 3. If a hit clears the reported way, `vic_vld` goes low on the next cycle.
- R4: A fill writes `fill_rrpv` into the filled way. A hit to a different way in the same cycle is also applied. When a hit and a fill target the same way, the fill value wins.
- R5: When several ways hold 3, `vic_way` is the lowest-numbered of them.
- R6: When no way holds 3, all ways rise by one per cycle while the request is held, and `vic_vld` stays low throughout. With a largest value m, `vic_vld` rises on the edge numbered 5−m, counting the edge that first samples the request as edge 1.
- R7: Transitions: `ST_IDLE` moves to `ST_FOUND` on the next edge when a distant way exists. `ST_FOUND` moves to `ST_AGE` when the request is held and no distant way remains, and aging then continues as in R6.
- R8: Withdrawing the request in `ST_AGE` or `ST_FOUND` returns to `ST_IDLE` and stops aging. Values that were already aged are kept.
- R9: A way filled with 3 is a victim without aging. A way filled with 2, with all other ways at 0, becomes the victim after exactly one aging step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld | input | 1 | Hit strobe |
| hit_way | input | 4 | Way that hit |
| fill_vld | input | 1 | Fill strobe |
| fill_way | input | 4 | Way being filled |
| fill_rrpv | input | 2 | Insertion value for the filled way |
| vic_req | input | 1 | Victim request, held until served |
| vic_vld | output | 1 | Victim index is valid |
| vic_way | output | 4 | Lowest-numbered distant way |

## Verification
The assertions assume that reset is applied before any strobe. They also assume that a hit and a fill to the same way in one cycle resolve to the fill, so the hit check is guarded by the absence of a fill. The stimulus drives every input between clock edges. It sends a hit and a fill to the same way only in the one directed priority test, and it uses way indices in the range 0 to 15 throughout. The aging and withdrawal tests start from a known state: the set is reset and then hit in every way, which puts every value at 0.

// File: rtl/rrip_pkg.sv
package rrip_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_AGE   = 2'd1,
        ST_FOUND = 2'd2
    } repl_state_e;
endpackage

// File: rtl/rrip_way_ctr.sv
module rrip_way_ctr #(
    parameter int RRPV_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_sel,
    input  logic              fill_sel,
    input  logic [RRPV_W-1:0] fill_val,
    input  logic              age_en,
    output logic [RRPV_W-1:0] val
);
    localparam logic [RRPV_W-1:0] RRPV_MAX = {RRPV_W{1'b1}};

    // fill wins over hit, hit wins over aging
    always_ff @(posedge clk) begin
        if (!rst_n)                        val <= RRPV_MAX;
        else if (fill_sel)                 val <= fill_val;
        else if (hit_sel)                  val <= '0;
        else if (age_en && val != RRPV_MAX) val <= val + 1'b1;
    end

    AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_sel && !fill_sel |=> val == '0);                                 // R2
    AST_FILL_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        fill_sel |=> val == $past(fill_val));                                // R4
    AST_AGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        age_en && !hit_sel && !fill_sel |=> val == RRPV_W'($past(val) + 1'b1)); // R6
    AST_AGE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        age_en |-> val != RRPV_MAX);                                         // R6
endmodule

// File: rtl/rrip_victim_pick.sv
module rrip_victim_pick #(
    parameter int NUM_WAYS = 16,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] distant,
    output logic                found,
    output logic [WAY_W-1:0]    idx
);
    always_comb begin
        idx = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (distant[i]) idx = WAY_W'(i);
        end
        found = |distant;
    end
endmodule

// File: rtl/rrip_set_repl.sv
module rrip_set_repl
    import rrip_pkg::*;
#(
    parameter int NUM_WAYS = 16,
    parameter int RRPV_W   = 2,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_vld,
    input  logic [WAY_W-1:0]  hit_way,
    input  logic              fill_vld,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [RRPV_W-1:0] fill_rrpv,
    input  logic              vic_req,
    output logic              vic_vld,
    output logic [WAY_W-1:0]  vic_way
);
    localparam logic [RRPV_W-1:0] RRPV_MAX = {RRPV_W{1'b1}};

    repl_state_e          state, state_nxt;
    logic [RRPV_W-1:0]    way_val [NUM_WAYS];
    logic [NUM_WAYS-1:0]  distant;
    logic                 any_distant;
    logic [WAY_W-1:0]     pick_idx;
    logic                 age_en;

    assign age_en = (state == ST_AGE) && vic_req && !any_distant;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        rrip_way_ctr #(.RRPV_W(RRPV_W)) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit_sel  (hit_vld  && (hit_way  == WAY_W'(g))),
            .fill_sel (fill_vld && (fill_way == WAY_W'(g))),
            .fill_val (fill_rrpv),
            .age_en   (age_en),
            .val      (way_val[g])
        );
        assign distant[g] = (way_val[g] == RRPV_MAX);
    end

    rrip_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .distant (distant),
        .found   (any_distant),
        .idx     (pick_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (vic_req) state_nxt = any_distant ? ST_FOUND : ST_AGE;
            ST_AGE:   if (!vic_req) state_nxt = ST_IDLE;
                      else if (any_distant) state_nxt = ST_FOUND;
            ST_FOUND: if (!vic_req) state_nxt = ST_IDLE;
                      else if (!any_distant) state_nxt = ST_AGE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        vic_vld = (state == ST_FOUND) && any_distant;
        vic_way = pick_idx;
    end

    AST_VICTIM_DISTANT: assert property (@(posedge clk) disable iff (!rst_n)
        vic_vld |-> way_val[vic_way] == RRPV_MAX);                           // R3
    AST_VICTIM_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        vic_vld |-> (distant & ((NUM_WAYS'(1) << vic_way) - NUM_WAYS'(1))) == '0); // R5
    AST_DROP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_req |=> state == ST_IDLE);                                      // R8
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vic_req) |-> !vic_vld);                                       // R7
endmodule

// File: tb/rrip_set_repl_tb.sv
module rrip_set_repl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       hit_vld, fill_vld, vic_req;
    logic [3:0] hit_way, fill_way;
    logic [1:0] fill_rrpv;
    logic       vic_vld;
    logic [3:0] vic_way;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rrip_set_repl u_dut (
        .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_way(hit_way),
        .fill_vld(fill_vld), .fill_way(fill_way), .fill_rrpv(fill_rrpv),
        .vic_req(vic_req), .vic_vld(vic_vld), .vic_way(vic_way)
    );

    // {hit_v, hit_w[4], fill_v, fill_w[4], fill_val[2], req, exp_vld, exp_way[4]}
    localparam int NV = 7;
    localparam logic [17:0] VEC [NV] = '{
        {1'b1, 4'd0, 1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 4'd0},  // R2 hit way0
        {1'b1, 4'd1, 1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 4'd0},  // R2 hit way1
        {1'b0, 4'd0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b1, 4'd2},  // R5 lowest distant
        {1'b1, 4'd2, 1'b0, 4'd0, 2'd0, 1'b1, 1'b1, 4'd3},  // R3 hit victim
        {1'b0, 4'd0, 1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 4'd0},  // R8 drop
        {1'b1, 4'd4, 1'b1, 4'd3, 2'd0, 1'b0, 1'b0, 4'd0},  // R4 hit+fill
        {1'b0, 4'd0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b1, 4'd5}   // R4 result
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        hit_vld = 1'b0; hit_way = '0; fill_vld = 1'b0; fill_way = '0;
        fill_rrpv = '0; vic_req = 1'b0;
    endtask

    task automatic chk(input string tag, input logic ev, input logic [3:0] ew);
        n_chk++;
        if (vic_vld !== ev || (ev && vic_way !== ew)) begin
            n_fail++;
            $display("FAIL %s: vld=%0b way=%0d expected vld=%0b way=%0d",
                     tag, vic_vld, vic_way, ev, ew);
        end
    endtask

    task automatic do_reset();
        quiet();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic hit_all();
        for (int w = 0; w < 16; w++) begin
            hit_vld = 1'b1; hit_way = 4'(w);
            step();
        end
        quiet();
    endtask

    initial begin
        do_reset();
        chk("R1 reset idle", 1'b0, 4'd0);
        vic_req = 1'b1; step();
        chk("R1 victim after reset", 1'b1, 4'd0);

        // table walk from a fresh reset
        do_reset();
        for (int i = 0; i < NV; i++) begin
            hit_vld = VEC[i][17]; hit_way = VEC[i][16:13];
            fill_vld = VEC[i][12]; fill_way = VEC[i][11:8];
            fill_rrpv = VEC[i][7:6]; vic_req = VEC[i][5];
            step();
            chk($sformatf("R2/R3/R4/R5/R8 vector %0d", i), VEC[i][4], VEC[i][3:0]);
        end
        quiet(); step();

        // R6: all zero, aging takes three steps
        do_reset(); hit_all();
        vic_req = 1'b1;
        for (int e = 1; e <= 4; e++) begin
            step(); chk($sformatf("R6 low during aging edge %0d", e), 1'b0, 4'd0);
        end
        step(); chk("R6 victim after aging", 1'b1, 4'd0);
        quiet(); step();

        // R9: scan insertion value 2 needs one aging step
        do_reset(); hit_all();
        fill_vld = 1'b1; fill_way = 4'd7; fill_rrpv = 2'd2; step(); quiet();
        vic_req = 1'b1;
        step(); chk("R9 far fill edge1", 1'b0, 4'd0);
        step(); chk("R9 far fill edge2", 1'b0, 4'd0);
        step(); chk("R9 far fill victim", 1'b1, 4'd7);
        quiet(); step();

        // R9: thrash insertion value 3 is an immediate victim
        do_reset(); hit_all();
        fill_vld = 1'b1; fill_way = 4'd9; fill_rrpv = 2'd3; step(); quiet();
        vic_req = 1'b1; step();
        chk("R9 distant fill victim", 1'b1, 4'd9);
        quiet(); step();

        // R4: same-way hit and fill, fill wins
        do_reset(); hit_all();
        hit_vld = 1'b1; hit_way = 4'd5; fill_vld = 1'b1; fill_way = 4'd5; fill_rrpv = 2'd3;
        step(); quiet();
        vic_req = 1'b1; step();
        chk("R4 fill beats hit", 1'b1, 4'd5);
        quiet(); step();

        // R7: found -> age after the victim is hit
        do_reset(); hit_all();
        fill_vld = 1'b1; fill_way = 4'd4; fill_rrpv = 2'd3; step(); quiet();
        vic_req = 1'b1; step();
        chk("R7 idle to found", 1'b1, 4'd4);
        hit_vld = 1'b1; hit_way = 4'd4; step(); hit_vld = 1'b0;
        chk("R3 victim cleared by hit", 1'b0, 4'd0);
        for (int e = 3; e <= 6; e++) begin
            step(); chk($sformatf("R7 re-aging edge %0d", e), 1'b0, 4'd0);
        end
        step(); chk("R7 victim after re-aging", 1'b1, 4'd0);
        quiet(); step();

        // R8: withdrawal stops aging but keeps aged values
        do_reset(); hit_all();
        vic_req = 1'b1; step(); step();
        vic_req = 1'b0; step();
        chk("R8 withdrawn idle", 1'b0, 4'd0);
        vic_req = 1'b1;
        step(); step(); step();
        chk("R8 no extra aging", 1'b0, 4'd0);
        step(); chk("R8 victim resumes", 1'b1, 4'd0);
        quiet(); step();

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule